// File: doc/BRIEF.md
# Compressed-to-Full Instruction Expander

This unit is a pipeline stage placed in front of an existing 32-bit instruction decoder. Each cycle it takes a 32-bit fetch word, address bit A1 and a state flag that says whether the core is running 16-bit compressed code. In 32-bit state the fetch word is forwarded as it is. In compressed state, A1 picks one 16-bit halfword out of the fetch word. The unit then rewrites that halfword into the equivalent full-width instruction, so the downstream decoder needs no second decode path.

Five compressed shapes are rewritten: a move with an immediate shift, a three-operand add or subtract, the move/compare/add/subtract group with an 8-bit constant, an unconditional branch, and the two-halfword branch-with-link. A compressed instruction can only name the low eight registers, so bit 3 of each expanded register field is forced to 0. Every expanded instruction carries the "always" condition code 4'hE in bits [31:28].

The branch-with-link arrives as two separate halfwords. The first half is held inside the unit, and one combined instruction comes out when the second half arrives. A second half that has no first half ahead of it raises an error flag. Results are registered, so each output appears one clock after its input.

Top module: `instr_expander`

## Requirements
- R1: When cstate=0, the unit presents fetch_word on instr_out with instr_valid=1 one clock later. This holds for either value of addr_a1.
- R2: When cstate=1, the unit expands the halfword fetch_word[31:16] if addr_a1=1 and fetch_word[15:0] if addr_a1=0. Bits outside the selected half have no effect.
- R3: A shift halfword has h[15:13]=000 and h[12:11]≠11, with op=h[12:11] (00 LSL, 01 LSR, 10 ASR), amount=h[10:6], Rs=h[5:3] and Rd=h[2:0]. It expands to 0xE1B00000 | Rd<<12 | amount<<7 | op<<5 | Rs.
- R4: An add/subtract halfword has h[15:11]=00011, with I=h[10], sub=h[9], x=h[8:6], Rs=h[5:3] and Rd=h[2:0]. It expands to a base | Rs<<16 | Rd<<12 | x. The base is 0xE0900000 for a register add, 0xE0500000 for a register subtract, 0xE2900000 for an immediate add and 0xE2500000 for an immediate subtract.
- R5: An immediate-group halfword has h[15:13]=001, with op=h[12:11], Rd=h[10:8] and imm8=h[7:0]. The constant is zero-extended with rotate amount 0.
  - op=00 (move) expands to 0xE3B00000 | Rd<<12 | imm8.
  - op=01 (compare) expands to 0xE3500000 | Rd<<16 | imm8.
  - op=10 (add) expands to 0xE2900000 | Rd<<16 | Rd<<12 | imm8, so Rd is both the destination and the first source.
  - op=11 (subtract) expands to 0xE2500000 | Rd<<16 | Rd<<12 | imm8.
- R6: A branch halfword has h[15:11]=11100. It expands to 0xEA000000 | the 24-bit sign extension of h[10:0], which is a halfword offset.
- R7: A link-first halfword has h[15:11]=11110. The next cycle shows instr_valid=0, instr_out=0 and bl_error=0. The unit holds h[10:0] as the upper 11 offset bits.
- R8: A link-second halfword has h[15:11]=11111. If a first half is held, it expands to 0xEB000000 | the 24-bit sign extension of {held, h[10:0]}, and the held first half is released.
- R9: A link-second halfword with no held first half gives bl_error=1 for one cycle, with instr_valid=0 and instr_out=0.
- R10: A compressed halfword of any other shape gives instr_valid=0 and instr_out=0. Whenever instr_valid=0, instr_out is 0.
- R11: While a first half is held, other compressed instructions expand normally and leave it held. A new first half replaces the held bits. A cycle in 32-bit state discards the held half.
- R12: While rst_n=0, instr_out=0, instr_valid=0 and bl_error=0. Reset discards any held first half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_word | input | 32 | Fetched instruction word |
| addr_a1 | input | 1 | Address bit A1; selects the halfword in compressed state |
| cstate | input | 1 | 1 = compressed 16-bit state, 0 = 32-bit state |
| instr_out | output | 32 | Instruction handed to the decoder |
| instr_valid | output | 1 | instr_out holds an instruction |
| bl_error | output | 1 | Link-second halfword arrived with no first half |

## Verification
The case of interest is two functions acting in the same cycle: an ordinary expansion and the branch-with-link holding state. It comes up when a first half is held and an unrelated compressed instruction arrives next. The unit must emit the expansion and keep the held half untouched. A state switch or a second first half in the held window is also tested, since it must discard or replace the held bits. Directed sequences provoke these cases, and a long pseudo-random run weighted toward link halfwords adds more. A behavioural model judges every cycle by tracking the held half on its own.

// File: rtl/instr_exp_pkg.sv
// Package: shared widths, condition code and halfword classes for the
// compressed-instruction expander. Assumes a 32-bit word made of two halfwords.
package instr_exp_pkg;
    localparam int WORD_W    = 32;
    localparam int HALF_W    = 16;
    localparam int LANES     = WORD_W / HALF_W;
    localparam int LANE_W    = $clog2(LANES);
    localparam int LREG_W    = 3;
    localparam int OFF_W     = 11;
    localparam int BOFF_W    = 24;
    localparam logic [3:0] COND_ALWAYS = 4'hE;

    typedef enum logic [2:0] {
        HK_NONE, HK_SHIFT, HK_ADDSUB, HK_IMM, HK_BRANCH, HK_LINK_HI, HK_LINK_LO
    } hw_kind_t;

    // Sort a halfword into one of the handled shapes.
    function automatic hw_kind_t classify(input logic [HALF_W-1:0] h);
        if (h[15:11] == 5'b00011)      return HK_ADDSUB;
        else if (h[15:13] == 3'b000)   return HK_SHIFT;
        else if (h[15:13] == 3'b001)   return HK_IMM;
        else if (h[15:11] == 5'b11100) return HK_BRANCH;
        else if (h[15:11] == 5'b11110) return HK_LINK_HI;
        else if (h[15:11] == 5'b11111) return HK_LINK_LO;
        else                           return HK_NONE;
    endfunction
endpackage

// File: rtl/half_select.sv
// half_select: picks one halfword lane from the fetch word by address bits.
// Assumes lane 0 is the low-order halfword (little-endian packing).
module half_select
    import instr_exp_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [LANE_W-1:0] lane,
    output logic [HALF_W-1:0] half
);
    logic [HALF_W-1:0] lanes [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes[g] = word[g*HALF_W +: HALF_W];
    end

    // Route the addressed lane to the output.
    always_comb half = lanes[lane];
endmodule

// File: rtl/hw_expand.sv
// hw_expand: combinational rewrite of one compressed halfword into a full
// instruction for the non-link shapes. Assumes only the low eight registers
// are nameable, so register field bit 3 is always 0.
module hw_expand
    import instr_exp_pkg::*;
(
    input  logic [HALF_W-1:0] half,
    output hw_kind_t          kind,
    output logic [WORD_W-1:0] word,
    output logic              ok
);
    logic [LREG_W-1:0] rd_lo, rs_lo, rd_hi;
    logic [3:0]        imm_op;

    assign rd_lo = half[2:0];
    assign rs_lo = half[5:3];
    assign rd_hi = half[10:8];

    // Map the immediate-group operation onto the full data-processing opcode.
    always_comb begin
        case (half[12:11])
            2'b00:   imm_op = 4'b1101;
            2'b01:   imm_op = 4'b1010;
            2'b10:   imm_op = 4'b0100;
            default: imm_op = 4'b0010;
        endcase
    end

    // Build the expanded word for the recognised shape.
    always_comb begin
        kind = classify(half);
        ok   = 1'b1;
        word = '0;
        case (kind)
            HK_SHIFT:  word = {COND_ALWAYS, 3'b000, 4'b1101, 1'b1, 4'h0,
                               1'b0, rd_lo, half[10:6], half[12:11], 1'b0,
                               1'b0, rs_lo};
            HK_ADDSUB: word = {COND_ALWAYS, 2'b00, half[10],
                               (half[9] ? 4'b0010 : 4'b0100), 1'b1,
                               1'b0, rs_lo, 1'b0, rd_lo, 9'd0, half[8:6]};
            HK_IMM:    word = {COND_ALWAYS, 2'b00, 1'b1, imm_op, 1'b1,
                               (half[12:11] == 2'b00) ? 4'h0 : {1'b0, rd_hi},
                               (half[12:11] == 2'b01) ? 4'h0 : {1'b0, rd_hi},
                               4'h0, half[7:0]};
            HK_BRANCH: word = {COND_ALWAYS, 4'b1010,
                               {(BOFF_W-OFF_W){half[OFF_W-1]}}, half[OFF_W-1:0]};
            default:   ok   = 1'b0;
        endcase
    end
endmodule

// File: rtl/link_joiner.sv
// link_joiner: holds the first half of a two-halfword branch-with-link and
// forms the joined instruction when the second half arrives. Assumes the
// held half is dropped whenever the core is in 32-bit state.
module link_joiner
    import instr_exp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cstate,
    input  hw_kind_t          kind,
    input  logic [OFF_W-1:0]  off,
    output logic [WORD_W-1:0] link_word,
    output logic              link_ok,
    output logic              link_err
);
    localparam int JOIN_W = 2 * OFF_W;

    logic             pend_q;
    logic [OFF_W-1:0] hi_q;
    logic [JOIN_W-1:0] joined;

    assign joined = {hi_q, off};

    // Track the pending first half.
    always_ff @(posedge clk) begin
        if (!rst_n || !cstate) begin
            pend_q <= 1'b0;
            hi_q   <= '0;
        end else if (kind == HK_LINK_HI) begin
            pend_q <= 1'b1;
            hi_q   <= off;
        end else if (kind == HK_LINK_LO) begin
            pend_q <= 1'b0;
        end
    end

    // Form the joined instruction or flag an orphan second half.
    always_comb begin
        link_word = {COND_ALWAYS, 4'b1011,
                     {(BOFF_W-JOIN_W){joined[JOIN_W-1]}}, joined};
        link_ok   = cstate && (kind == HK_LINK_LO) && pend_q;
        link_err  = cstate && (kind == HK_LINK_LO) && !pend_q;
    end
endmodule

// File: rtl/instr_expander.sv
// instr_expander: pipeline stage ahead of the full-width decoder. It forwards
// 32-bit-state words and expands compressed halfwords. Assumes one fetch word
// per clock; all outputs are registered (one cycle of latency).
module instr_expander
    import instr_exp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       fetch_word,
    input  logic              addr_a1,
    input  logic              cstate,
    output logic [31:0]       instr_out,
    output logic              instr_valid,
    output logic              bl_error
);
    logic [HALF_W-1:0] half;
    hw_kind_t          kind;
    logic [WORD_W-1:0] exp_word, link_word;
    logic              exp_ok, link_ok, link_err;

    half_select u_sel (.word(fetch_word), .lane(addr_a1), .half(half));

    hw_expand u_exp (.half(half), .kind(kind), .word(exp_word), .ok(exp_ok));

    link_joiner u_link (
        .clk(clk), .rst_n(rst_n), .cstate(cstate), .kind(kind),
        .off(half[OFF_W-1:0]), .link_word(link_word),
        .link_ok(link_ok), .link_err(link_err)
    );

    // Register the selected result toward the decoder.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            instr_out   <= '0;
            instr_valid <= 1'b0;
            bl_error    <= 1'b0;
        end else if (!cstate) begin
            instr_out   <= fetch_word;
            instr_valid <= 1'b1;
            bl_error    <= 1'b0;
        end else begin
            instr_out   <= link_ok ? link_word : (exp_ok ? exp_word : '0);
            instr_valid <= link_ok || exp_ok;
            bl_error    <= link_err;
        end
    end
endmodule

// File: rtl/instr_expander_chk.sv
// instr_expander_chk: port-level properties of the expander, bound to it.
// Assumes the halfword layout stated in the requirements.
module instr_expander_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] fetch_word,
    input logic        addr_a1,
    input logic        cstate,
    input logic [31:0] instr_out,
    input logic        instr_valid,
    input logic        bl_error
);
    logic [15:0] h_in;
    assign h_in = addr_a1 ? fetch_word[31:16] : fetch_word[15:0];

    AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
        !cstate |=> instr_valid && instr_out == $past(fetch_word)); // R1
    AST_LINK_HI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cstate && h_in[15:11] == 5'b11110) |=> !instr_valid && !bl_error); // R7
    AST_ERR_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        bl_error |-> !instr_valid && instr_out == 32'h0); // R9
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |-> instr_out == 32'h0); // R10
    AST_COND_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (cstate && h_in[15:13] != 3'b010 && h_in[15:13] != 3'b011) |=>
            (!instr_valid || instr_out[31:28] == 4'hE)); // R2
    AST_RESET_QUIET: assert property (@(posedge clk)
        !$past(rst_n) |-> !instr_valid && !bl_error); // R12
endmodule

bind instr_expander instr_expander_chk u_chk (
    .clk(clk), .rst_n(rst_n), .fetch_word(fetch_word), .addr_a1(addr_a1),
    .cstate(cstate), .instr_out(instr_out), .instr_valid(instr_valid),
    .bl_error(bl_error)
);

// File: tb/instr_expander_test.sv
// Bench: behavioural reference model compared against the expander every clock.
module instr_expander_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_word = 32'hDEADBEEF;
    logic        addr_a1 = 1'b1;
    logic        cstate = 1'b1;
    logic [31:0] instr_out;
    logic        instr_valid, bl_error;

    int checks = 0;
    int fails = 0;
    bit m_pend = 0;
    int m_hi = 0;
    logic [31:0] lfsr = 32'h1234_5678;

    always #2 clk = ~clk;

    instr_expander uut (
        .clk(clk), .rst_n(rst_n), .fetch_word(fetch_word), .addr_a1(addr_a1),
        .cstate(cstate), .instr_out(instr_out), .instr_valid(instr_valid),
        .bl_error(bl_error)
    );

    function automatic logic [31:0] sext(input int v, input int bits);
        int x = v;
        if (x >= (1 << (bits - 1))) x = x - (1 << bits);
        return 32'(x) & 32'h00FF_FFFF;
    endfunction

    task automatic check(input string tag, input logic [31:0] ew,
                         input logic ev, input logic ee);
        checks++;
        if (instr_out !== ew || instr_valid !== ev || bl_error !== ee) begin
            fails++;
            $display("FAIL %s: actual out=%h v=%b e=%b expected out=%h v=%b e=%b",
                     tag, instr_out, instr_valid, bl_error, ew, ev, ee);
        end
    endtask

    task automatic step(input logic [31:0] w, input logic a1, input logic cs,
                        input string tag);
        logic [15:0] h;
        logic [31:0] ew = 0;
        logic ev = 0, ee = 0;
        int rd, rs, op;
        fetch_word = w; addr_a1 = a1; cstate = cs;
        h = a1 ? w[31:16] : w[15:0];
        rd = int'(h[2:0]); rs = int'(h[5:3]);
        if (!cs) begin
            ev = 1; ew = w; m_pend = 0;
        end else if (h[15:11] == 5'b11110) begin
            m_pend = 1; m_hi = int'(h[10:0]);
        end else if (h[15:11] == 5'b11111) begin
            if (m_pend) begin ev = 1; ew = 32'hEB00_0000 | sext(m_hi * 2048 + int'(h[10:0]), 22); end
            else ee = 1;
            m_pend = 0;
        end else if (h[15:11] == 5'b00011) begin
            ev = 1;
            ew = (h[10] ? 32'h0200_0000 : 0) | (h[9] ? 32'hE050_0000 : 32'hE090_0000)
                 | (rs << 16) | (rd << 12) | int'(h[8:6]);
        end else if (h[15:13] == 3'b000) begin
            ev = 1;
            ew = 32'hE1B0_0000 | (rd << 12) | (int'(h[10:6]) << 7) | (int'(h[12:11]) << 5) | rs;
        end else if (h[15:13] == 3'b001) begin
            ev = 1; rd = int'(h[10:8]); op = int'(h[12:11]);
            case (op)
                0: ew = 32'hE3B0_0000 | (rd << 12);
                1: ew = 32'hE350_0000 | (rd << 16);
                2: ew = 32'hE290_0000 | (rd << 16) | (rd << 12);
                default: ew = 32'hE250_0000 | (rd << 16) | (rd << 12);
            endcase
            ew = ew | int'(h[7:0]);
        end else if (h[15:11] == 5'b11100) begin
            ev = 1; ew = 32'hEA00_0000 | sext(int'(h[10:0]), 11);
        end
        @(posedge clk); @(negedge clk);
        check(tag, ew, ev, ee);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R12 reset quiet", 32'h0, 1'b0, 1'b0);
        fetch_word = 32'h0000_F801; addr_a1 = 0; cstate = 1;
        @(negedge clk);
        rst_n = 1'b1;
        m_pend = 0;
        step(32'h0000_F801, 0, 1, "R12 R9 orphan after reset");
        step(32'hCAFE_1234, 0, 0, "R1 pass a1=0");
        step(32'h0BAD_F00D, 1, 0, "R1 pass a1=1");
        step(32'hFFFF_0000, 1, 0, "R1 pass all-ones half");
        step(32'h1234_00CA, 0, 1, "R2 R3 LSL low half");
        step(32'h0FFF_ABCD, 1, 1, "R2 R3 LSR high half");
        step(32'h17FF_0000, 1, 1, "R3 ASR max amount");
        step(32'h0000_1999, 0, 1, "R4 add register");
        step(32'h0000_1BFF, 0, 1, "R4 sub register");
        step(32'h1D53_0000, 1, 1, "R4 add immediate");
        step(32'h0000_1FC1, 0, 1, "R4 sub immediate");
        step(32'h0000_27FF, 0, 1, "R5 move imm 0xFF");
        step(32'h0000_2C80, 0, 1, "R5 compare");
        step(32'h0000_3201, 0, 1, "R5 add Rd both");
        step(32'h0000_3FFE, 0, 1, "R5 subtract");
        step(32'h0000_E400, 0, 1, "R6 branch negative");
        step(32'h0000_E3FF, 0, 1, "R6 branch positive");
        step(32'hF400_0000, 1, 1, "R7 link first");
        step(32'hF801_0000, 1, 1, "R8 link second");
        step(32'h0000_F801, 0, 1, "R9 second again orphan");
        step(32'h0000_F3FF, 0, 1, "R11 first");
        step(32'h0000_2055, 0, 1, "R11 between keeps hold");
        step(32'h0000_F001, 0, 1, "R11 first replaces");
        step(32'h0000_FFFF, 0, 1, "R11 R8 joined replaced");
        step(32'h0000_F123, 0, 1, "R11 first before switch");
        step(32'h0000_F801, 0, 0, "R11 32-bit state");
        step(32'h0000_F801, 0, 1, "R11 hold dropped");
        step(32'h0000_4000, 0, 1, "R10 other shape");
        step(32'h0000_B000, 0, 1, "R10 other shape high");
        for (int i = 0; i < 400; i++) begin
            logic [31:0] w;
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            w = lfsr;
            if (lfsr[7:6] == 2'b11) w[15:12] = 4'hF;
            if (lfsr[9:8] == 2'b11) w[31:28] = 4'hF;
            step(w, lfsr[20], lfsr[23:21] != 3'b000, "R2 R11 random");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule